// File: doc/BRIEF.md
# Receiver clock source mode controller

This block makes the routing decisions for the master clock output and the serial data output of a digital audio receiver. A 2-bit mode select chooses between running from the recovered PLL clock with received data, running from the crystal with an auxiliary data input, switching between the two automatically from the PLL lock state, or running from the crystal while the PLL keeps running for monitoring. The block drives a clock-source select, a data-source select, a PLL power enable and a crystal oscillator enable. It also reports an unlock status flag.

The lock input is combined with a sync-error indication: a wrong received sync interval counts as loss of lock. The combined lock is synchronized into the reference clock domain. In the automatic mode it is then debounced, so that the route changes only after the lock state has held for a programmable number of cycles. The crystal is powered down only when nothing needs it: the PLL-only mode is active and the rate-detection select says the crystal is not used for comparison. The glitch-free clock multiplexer, the PLL and the oscillator themselves are not part of this block.

Top module: `rx_clksrc_ctrl`

## Requirements
- R1: While rst_n is low, and after reset until inputs change, the outputs are clk_sel_xtal=0, data_sel_aux=0, pll_pwr_en=1, xtal_en=1 and unlock_flag=1. The mode register resets to mode 0.
- R2: Mode 0 (mode_sel=00) gives clk_sel_xtal=0 (PLL clock), data_sel_aux=0 (received data) and pll_pwr_en=1, whatever the lock state.
- R3: Mode 1 (mode_sel=01) gives clk_sel_xtal=1 (crystal), data_sel_aux=1 (auxiliary input) and pll_pwr_en=0.
- R4: Mode 2 (mode_sel=10) keeps pll_pwr_en=1. With the qualified lock at 1 it gives clk_sel_xtal=0 and data_sel_aux=0. With the qualified lock at 0 it gives clk_sel_xtal=1 and data_sel_aux=1. clk_sel_xtal always equals data_sel_aux.
- R5: Mode 3 (mode_sel=11) gives clk_sel_xtal=1, data_sel_aux=1 and pll_pwr_en=1, whatever the lock state.
- R6: xtal_en is 0 only when mode 0 is active and rate_det_sel=11. In every other case it is 1.
- R7: The effective lock is pll_lock AND NOT sync_err. A high sync_err counts as unlocked even while pll_lock is 1.
- R8: In mode 2 a change of effective lock reaches clk_sel_xtal exactly SYNC_STAGES+STABLE_CYCLES+1 rising edges after the input change. An effective-lock excursion shorter than STABLE_CYCLES cycles leaves the route unchanged.
- R9: unlock_flag equals NOT effective lock, delayed by SYNC_STAGES rising edges.
- R10: A new mode_sel or rate_det_sel value reaches the route outputs exactly 2 rising edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Clock operation mode (00, 01, 10, 11) |
| rate_det_sel | input | 2 | Rate-detection select; 11 means the crystal is not used for comparison |
| pll_lock | input | 1 | Raw PLL lock indication |
| sync_err | input | 1 | High when the received sync interval is wrong |
| clk_sel_xtal | output | 1 | 1 = master clock from crystal, 0 = from PLL |
| data_sel_aux | output | 1 | 1 = serial data from auxiliary input, 0 = received data |
| pll_pwr_en | output | 1 | PLL power enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| unlock_flag | output | 1 | Registered inverse of effective lock |

## Verification
The bench sweeps every combination of mode, rate select, lock and sync error after the block has settled. A wrong decode table, a crystal shut off in the wrong mode, or sync_err being ignored would each show up as a mismatched output vector. It counts rising edges across lock changes in mode 2 to find the exact switch cycle. A filter that is off by one, or one that lets a short lock dropout through, would switch the clock one cycle early or late, or would switch on a glitch. It also checks the two-edge mode latency and the synchronizer delay of the unlock flag, which an extra or missing register would shift.

// File: rtl/rx_clksrc_pkg.sv
package rx_clksrc_pkg;

   typedef enum logic [1:0] {
      CS_PLL_ONLY  = 2'b00,
      CS_XTAL_ONLY = 2'b01,
      CS_AUTO      = 2'b10,
      CS_XTAL_MON  = 2'b11
   } cs_mode_e;

   localparam logic [1:0] RATE_NO_XTAL = 2'b11;

   typedef struct packed {
      logic clk_xtal;
      logic data_aux;
      logic pll_on;
      logic xtal_on;
   } cs_route_t;

   function automatic cs_route_t cs_route(cs_mode_e m, logic locked, logic [1:0] rate);
      cs_route_t r;
      r.clk_xtal = 1'b1;
      r.data_aux = 1'b1;
      r.pll_on   = 1'b1;
      r.xtal_on  = 1'b1;
      case (m)
         CS_PLL_ONLY: begin
            r.clk_xtal = 1'b0;
            r.data_aux = 1'b0;
            r.xtal_on  = (rate != RATE_NO_XTAL);
         end
         CS_XTAL_ONLY: r.pll_on = 1'b0;
         CS_AUTO: begin
            r.clk_xtal = ~locked;
            r.data_aux = ~locked;
         end
         default: r.pll_on = 1'b1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rx_lock_sync.sv
module rx_lock_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rx_lock_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rx_lock_filter.sv
module rx_lock_filter #(
   parameter int STABLE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic qual
);
   generate
      if (STABLE_CYCLES < 0) begin : g_bad_cycles
         $error("rx_lock_filter: STABLE_CYCLES must not be negative");
      end

      if (STABLE_CYCLES == 0) begin : g_bypass
         assign qual = raw;
      end else begin : g_debounce
         localparam int CNT_W = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
         localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);
         logic [CNT_W-1:0] run_q;
         logic             qual_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q  <= '0;
               qual_q <= 1'b0;
            end else if (raw == qual_q) begin
               run_q <= '0;
            end else if (run_q == LAST) begin
               run_q  <= '0;
               qual_q <= raw;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end

         assign qual = qual_q;
      end
   endgenerate
endmodule

// File: rtl/rx_clksrc_decode.sv
module rx_clksrc_decode
   import rx_clksrc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_sel,
   input  logic [1:0] rate_sel,
   input  logic       locked,
   output cs_route_t  route
);
   cs_mode_e  mode_q;
   logic [1:0] rate_q;
   cs_route_t route_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= CS_PLL_ONLY;
         rate_q  <= 2'b00;
         route_q <= cs_route(CS_PLL_ONLY, 1'b0, 2'b00);
      end else begin
         mode_q  <= cs_mode_e'(mode_sel);
         rate_q  <= rate_sel;
         route_q <= cs_route(mode_q, locked, rate_q);
      end
   end

   assign route = route_q;
endmodule

// File: rtl/rx_clksrc_ctrl.sv
module rx_clksrc_ctrl
   import rx_clksrc_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int STABLE_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_sel,
   input  logic [1:0] rate_det_sel,
   input  logic       pll_lock,
   input  logic       sync_err,
   output logic       clk_sel_xtal,
   output logic       data_sel_aux,
   output logic       pll_pwr_en,
   output logic       xtal_en,
   output logic       unlock_flag
);
   logic      lock_raw;
   logic      lock_sync;
   logic      lock_qual;
   cs_route_t route;

   // R7: a bad sync interval counts as loss of lock
   assign lock_raw = pll_lock & ~sync_err;

   rx_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(lock_raw), .q(lock_sync)
   );

   rx_lock_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filter (
      .clk(clk), .rst_n(rst_n), .raw(lock_sync), .qual(lock_qual)
   );

   rx_clksrc_decode u_decode (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rate_sel(rate_det_sel),
      .locked(lock_qual), .route(route)
   );

   assign clk_sel_xtal = route.clk_xtal;
   assign data_sel_aux = route.data_aux;
   assign pll_pwr_en   = route.pll_on;
   assign xtal_en      = route.xtal_on;
   assign unlock_flag  = ~lock_sync;   // R9
endmodule

// File: rtl/rx_clksrc_ctrl_chk.sv
module rx_clksrc_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_sel,
   input logic [1:0] rate_det_sel,
   input logic       clk_sel_xtal,
   input logic       data_sel_aux,
   input logic       pll_pwr_en,
   input logic       xtal_en,
   input logic       unlock_flag
);
   logic [1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hist_q <= 2'd0;
      else if (hist_q != 2'd3) hist_q <= hist_q + 2'd1;
   end

   p_mode0_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_q >= 2'd2 && $past(mode_sel, 2) == 2'b00) |->
      (!clk_sel_xtal && !data_sel_aux && pll_pwr_en));

   p_mode1_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_q >= 2'd2 && $past(mode_sel, 2) == 2'b01) |->
      (clk_sel_xtal && data_sel_aux && !pll_pwr_en));

   p_mode2_pll_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_q >= 2'd2 && $past(mode_sel, 2) == 2'b10) |-> pll_pwr_en);

   p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clk_sel_xtal == data_sel_aux);

   p_mode3_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_q >= 2'd2 && $past(mode_sel, 2) == 2'b11) |->
      (clk_sel_xtal && data_sel_aux && pll_pwr_en));

   p_xtal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_q >= 2'd2) |->
      (xtal_en == !($past(mode_sel, 2) == 2'b00 && $past(rate_det_sel, 2) == 2'b11)));

   p_fallback_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_q == 2'd3 && $past(mode_sel, 2) == 2'b10 && $past(mode_sel, 3) == 2'b10 &&
       clk_sel_xtal != $past(clk_sel_xtal)) |-> (clk_sel_xtal == $past(unlock_flag)));
endmodule

bind rx_clksrc_ctrl rx_clksrc_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rate_det_sel(rate_det_sel),
   .clk_sel_xtal(clk_sel_xtal), .data_sel_aux(data_sel_aux), .pll_pwr_en(pll_pwr_en),
   .xtal_en(xtal_en), .unlock_flag(unlock_flag)
);

// File: tb/rx_clksrc_ctrl_bench.sv
module rx_clksrc_ctrl_bench;
   localparam int S = 2;
   localparam int N = 4;
   localparam int SETTLE = S + N + 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic [1:0] rate_det_sel = 2'b00;
   logic       pll_lock = 1'b0;
   logic       sync_err = 1'b0;
   logic       clk_sel_xtal, data_sel_aux, pll_pwr_en, xtal_en, unlock_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rx_clksrc_ctrl #(.SYNC_STAGES(S), .STABLE_CYCLES(N)) u_rx_clksrc_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rate_det_sel(rate_det_sel),
      .pll_lock(pll_lock), .sync_err(sync_err), .clk_sel_xtal(clk_sel_xtal),
      .data_sel_aux(data_sel_aux), .pll_pwr_en(pll_pwr_en), .xtal_en(xtal_en),
      .unlock_flag(unlock_flag)
   );

   function automatic logic [4:0] expv(int m, int r, bit lk, bit se);
      bit eff = lk && !se;
      bit xc  = (m == 1) || (m == 3) || (m == 2 && !eff);
      return {xc, xc, (m != 1), !(m == 0 && r == 3), !eff};
   endfunction

   function automatic logic [4:0] outs();
      return {clk_sel_xtal, data_sel_aux, pll_pwr_en, xtal_en, unlock_flag};
   endfunction

   task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      step(3);
      chk("R1 in reset", outs(), 5'b00111);
      rst_n = 1'b1;
      step(1);
      chk("R1 after reset", outs(), 5'b00111);

      // Exhaustive settled sweep: R2 R3 R4 R5 R6 R7
      for (int m = 0; m < 4; m++)
         for (int r = 0; r < 4; r++)
            for (int l = 0; l < 2; l++)
               for (int e = 0; e < 2; e++) begin
                  string tag;
                  mode_sel = 2'(m); rate_det_sel = 2'(r);
                  pll_lock = 1'(l); sync_err = 1'(e);
                  step(SETTLE);
                  if (l == 1 && e == 1)        tag = "R7 sweep";
                  else if (m == 0 && r == 3)   tag = "R6 sweep";
                  else if (m == 0)             tag = "R2 sweep";
                  else if (m == 1)             tag = "R3 sweep";
                  else if (m == 2)             tag = "R4 sweep";
                  else                         tag = "R5 sweep";
                  chk(tag, outs(), expv(m, r, 1'(l), 1'(e)));
               end

      // R10: mode latency of 2 edges
      mode_sel = 2'b00; rate_det_sel = 2'b00; pll_lock = 1'b1; sync_err = 1'b0;
      step(SETTLE);
      mode_sel = 2'b01;
      step(1);
      chk("R10 mode edge1", outs(), expv(0, 0, 1, 0));
      step(1);
      chk("R10 mode edge2", outs(), expv(1, 0, 1, 0));
      rate_det_sel = 2'b11; mode_sel = 2'b00;
      step(1);
      chk("R10 rate edge1", outs(), expv(1, 3, 1, 0));
      step(1);
      chk("R10 rate edge2", outs(), expv(0, 3, 1, 0));

      // R9: unlock flag delay S edges
      rate_det_sel = 2'b00;
      step(SETTLE);
      pll_lock = 1'b0;
      step(S - 1);
      chk("R9 before", {4'b0, unlock_flag}, 5'b00000);
      step(1);
      chk("R9 at", {4'b0, unlock_flag}, 5'b00001);

      // R8: exact fallback and recovery timing in mode 2
      mode_sel = 2'b10; pll_lock = 1'b1;
      step(SETTLE);
      chk("R8 locked", outs(), expv(2, 0, 1, 0));
      sync_err = 1'b1;   // R7 path into the fallback
      step(S + N);
      chk("R8 fallback early", {4'b0, clk_sel_xtal}, 5'b00000);
      step(1);
      chk("R8 fallback at", {4'b0, clk_sel_xtal}, 5'b00001);
      sync_err = 1'b0;
      step(S + N);
      chk("R8 recover early", {4'b0, clk_sel_xtal}, 5'b00001);
      step(1);
      chk("R8 recover at", {4'b0, clk_sel_xtal}, 5'b00000);

      // R8: dropout of N-1 cycles is ignored
      step(SETTLE);
      begin
         bit moved = 1'b0;
         bit flag_seen = 1'b0;
         pll_lock = 1'b0;
         for (int i = 0; i < N - 1; i++) begin
            step(1);
            if (clk_sel_xtal) moved = 1'b1;
         end
         pll_lock = 1'b1;
         for (int i = 0; i < SETTLE; i++) begin
            step(1);
            if (clk_sel_xtal) moved = 1'b1;
            if (unlock_flag) flag_seen = 1'b1;
         end
         chk("R8 short dropout route", {4'b0, moved}, 5'b00000);
         chk("R9 short dropout flag", {4'b0, flag_seen}, 5'b00001);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule